// File: doc/BRIEF.md
# Dual-sided interprocessor messaging unit

This block links two processors, called side A and side B, that share one clock. Each side sees the same small register window: four outgoing data words, four incoming data words, a status word and a control word. It also has one interrupt line. A word written into an outgoing slot on one side appears in the matching incoming slot on the other side. Each slot has a full/empty handshake, so the sender knows when the receiver has consumed the word.

Beside the data path, each side can ring four doorbells on its peer. Each doorbell latches a pending bit there, and software clears that bit by writing a one to it. Each side can also drive three plain flag bits that the peer reads in its status word. Enable bits in the control word decide which status conditions raise the side's interrupt. In both words the per-channel bits run in reversed order, so channel 0 takes the highest bit of its group of four.

Top module: `dual_msg_unit`

## Requirements
- R1: After reset, every transmit-empty bit reads 1. Every receive-full and doorbell-pending bit reads 0, both control words read 0 and both interrupt lines are low.
- R2: Word offsets are outgoing slot n at 4*n, incoming slot n at 0x10+4*n, status at 0x20 and control at 0x24. Writing outgoing slot n clears the writer's transmit-empty bit n on the next cycle and sets the peer's receive-full bit n. The peer's incoming slot n then returns the written word.
- R3: Reading incoming slot n returns the word, clears receive-full bit n and sets the sender's transmit-empty bit n again.
- R4: In the status word, channel n has doorbell-pending at bit 31-n, receive-full at bit 27-n and transmit-empty at bit 23-n.
- R5: In the control word, channel n has doorbell enable at bit 31-n, receive enable at bit 27-n, transmit enable at bit 23-n and doorbell request at bit 19-n. The three flags sit at bits 2:0. All these fields read back as written, and the other bits read 0.
- R6: Writing a 1 to request bit n sets the peer's pending bit n one cycle later. The request bit reads 1 only in the cycle after the write and clears itself after that.
- R7: A pending bit clears when a 1 is written to its status position. Writing 0 leaves it set.
- R8: Control bits 2:0 of one side appear as status bits 2:0 of the other side.
- R9: A side's interrupt is high exactly when some pending, receive-full or transmit-empty status bit is set together with its enable.
- R10: Writes to an incoming slot and to status bits other than the pending bits have no effect. Outgoing slots and unmapped offsets read 0, reading an outgoing slot has no side effect, and status bit 9 reads 0.
- R11: If the sender writes slot n in the same cycle that the receiver reads it, the receiver gets the old word and receive-full stays set with the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | 6 | Side A byte offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid while a_rd is high |
| a_irq | output | 1 | Side A interrupt |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | 6 | Side B byte offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid while b_rd is high |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench goes after the reversed bit order. A design that packs channels low-to-high shows receive-full for slot 1 at bit 25 instead of bit 26, so the status compare fails. The doorbell request is read back in the single cycle it is in flight and again one cycle later. A request bit that sticks, or one that never sets the peer's pending bit, shows up there. Writes of 0 and of 1 to the pending bit separate a true write-one-to-clear from a plain overwrite. A write and a read of the same slot in one cycle catch a design that lets the read's clear beat the write.

// File: rtl/msgu_pkg.sv
package msgu_pkg;
   localparam int LANES        = 4;
   localparam int WORD_TX_BASE = 0;
   localparam int WORD_RX_BASE = 4;
   localparam int WORD_SR      = 8;
   localparam int WORD_CR      = 9;
   localparam int POS_PEND     = 28;
   localparam int POS_FULL     = 24;
   localparam int POS_EMPTY    = 20;
   localparam int POS_REQ      = 16;

   // channel 0 sits on the top bit of each four-bit group
   function automatic int lane_bit(input int base, input int ch);
      return base + LANES - 1 - ch;
   endfunction
endpackage

// File: rtl/msgu_link.sv
module msgu_link #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          full
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout <= '0;
         full <= 1'b0;
      end else if (push) begin
         dout <= din;
         full <= 1'b1;
      end else if (pop) begin
         full <= 1'b0;
      end
   end

   AST_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> full);                                                   // R2
   AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> !full);                                        // R3
   AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !push |=> $stable(dout));                                         // R10
   AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> (full && dout == $past(din)));                  // R11
endmodule

// File: rtl/msgu_side.sv
module msgu_side
   import msgu_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int NFLAG = 3,
   parameter int DW    = 32,
   parameter int AW    = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic                    rd,
   input  logic [AW-1:0]           addr,
   input  logic [DW-1:0]           wdata,
   output logic [DW-1:0]           rdata,
   output logic                    irq,
   output logic [NCH-1:0]          tx_push,
   output logic [NCH-1:0]          rx_pop,
   input  logic [NCH-1:0][DW-1:0]  rx_data,
   input  logic [NCH-1:0]          rx_full,
   input  logic [NCH-1:0]          tx_full,
   output logic [NCH-1:0]          req_out,
   input  logic [NCH-1:0]          req_in,
   output logic [NFLAG-1:0]        flag_out,
   input  logic [NFLAG-1:0]        flag_in
);
   localparam int WW = AW - 2;

   generate
      if (NCH < 1 || NCH > LANES) begin : g_bad_nch
         $error("NCH must be 1..4");
      end
      if (NFLAG < 1 || NFLAG > 8) begin : g_bad_flag
         $error("NFLAG must be 1..8 to stay below reserved bit 9");
      end
      if (DW != 32) begin : g_bad_dw
         $error("DW must be 32");
      end
      if (AW < 6) begin : g_bad_aw
         $error("AW must cover offset 0x24");
      end
   endgenerate

   logic [WW-1:0]    word;
   logic             aligned, sr_wr, cr_wr;
   logic [NCH-1:0]   gie_q, rie_q, tie_q, req_q, pend_q;
   logic [NCH-1:0]   wd_gie, wd_rie, wd_tie, wd_req, wd_pend;
   logic [NFLAG-1:0] flag_q;
   logic [DW-1:0]    sr_vec, cr_vec;
   logic             unused_ok;

   assign word      = addr[AW-1:2];
   assign aligned   = (addr[1:0] == 2'b00);
   assign sr_wr     = wr && aligned && (word == WW'(WORD_SR));
   assign cr_wr     = wr && aligned && (word == WW'(WORD_CR));
   assign unused_ok = ^wdata;

   genvar n;
   generate
      for (n = 0; n < NCH; n++) begin : g_ch
         assign wd_gie[n]  = wdata[lane_bit(POS_PEND,  n)];
         assign wd_rie[n]  = wdata[lane_bit(POS_FULL,  n)];
         assign wd_tie[n]  = wdata[lane_bit(POS_EMPTY, n)];
         assign wd_req[n]  = wdata[lane_bit(POS_REQ,   n)];
         assign wd_pend[n] = wdata[lane_bit(POS_PEND,  n)];
         assign tx_push[n] = wr && aligned && (word == WW'(WORD_TX_BASE + n));
         assign rx_pop[n]  = rd && aligned && (word == WW'(WORD_RX_BASE + n));

         AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            req_in[n] |=> pend_q[n]);                                   // R6
         AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[n] && !sr_wr) |=> pend_q[n]);                       // R7
         AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            (sr_wr && wd_pend[n] && !req_in[n]) |=> !pend_q[n]);        // R7
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie_q  <= '0;
         rie_q  <= '0;
         tie_q  <= '0;
         req_q  <= '0;
         pend_q <= '0;
         flag_q <= '0;
      end else begin
         req_q  <= cr_wr ? wd_req : '0;
         pend_q <= (pend_q & ~(sr_wr ? wd_pend : '0)) | req_in;
         if (cr_wr) begin
            gie_q  <= wd_gie;
            rie_q  <= wd_rie;
            tie_q  <= wd_tie;
            flag_q <= wdata[NFLAG-1:0];
         end
      end
   end

   always_comb begin
      sr_vec = '0;
      cr_vec = '0;
      for (int i = 0; i < NCH; i++) begin
         sr_vec[lane_bit(POS_PEND,  i)] = pend_q[i];
         sr_vec[lane_bit(POS_FULL,  i)] = rx_full[i];
         sr_vec[lane_bit(POS_EMPTY, i)] = ~tx_full[i];
         cr_vec[lane_bit(POS_PEND,  i)] = gie_q[i];
         cr_vec[lane_bit(POS_FULL,  i)] = rie_q[i];
         cr_vec[lane_bit(POS_EMPTY, i)] = tie_q[i];
         cr_vec[lane_bit(POS_REQ,   i)] = req_q[i];
      end
      sr_vec[NFLAG-1:0] = flag_in;
      cr_vec[NFLAG-1:0] = flag_q;
   end

   always_comb begin
      rdata = '0;
      if (rd && aligned) begin
         if (word == WW'(WORD_SR)) rdata = sr_vec;
         if (word == WW'(WORD_CR)) rdata = cr_vec;
         for (int i = 0; i < NCH; i++) begin
            if (word == WW'(WORD_RX_BASE + i)) rdata = rx_data[i];
         end
      end
   end

   assign irq      = |(pend_q & gie_q) | |(rx_full & rie_q) | |(~tx_full & tie_q);
   assign req_out  = req_q;
   assign flag_out = flag_q;

   AST_REQ_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !cr_wr |=> (req_out == '0));                                      // R6
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(flag_in) |-> $stable(sr_vec[NFLAG-1:0]));                 // R8
endmodule

// File: rtl/dual_msg_unit.sv
module dual_msg_unit #(
   parameter int NCH   = 4,
   parameter int NFLAG = 3,
   parameter int DW    = 32,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_wr,
   input  logic          a_rd,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wdata,
   output logic [DW-1:0] a_rdata,
   output logic          a_irq,
   input  logic          b_wr,
   input  logic          b_rd,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wdata,
   output logic [DW-1:0] b_rdata,
   output logic          b_irq
);
   logic [NCH-1:0]          a_push, a_pop, b_push, b_pop;
   logic [NCH-1:0]          ab_full, ba_full;
   logic [NCH-1:0][DW-1:0]  ab_data, ba_data;
   logic [NCH-1:0]          a_req, b_req;
   logic [NFLAG-1:0]        a_flag, b_flag;

   genvar n;
   generate
      for (n = 0; n < NCH; n++) begin : g_link
         msgu_link #(.DW(DW)) u_ab (
            .clk(clk), .rst_n(rst_n), .push(a_push[n]), .pop(b_pop[n]),
            .din(a_wdata), .dout(ab_data[n]), .full(ab_full[n]));
         msgu_link #(.DW(DW)) u_ba (
            .clk(clk), .rst_n(rst_n), .push(b_push[n]), .pop(a_pop[n]),
            .din(b_wdata), .dout(ba_data[n]), .full(ba_full[n]));
      end
   endgenerate

   msgu_side #(.NCH(NCH), .NFLAG(NFLAG), .DW(DW), .AW(AW)) u_side_a (
      .clk(clk), .rst_n(rst_n), .wr(a_wr), .rd(a_rd), .addr(a_addr),
      .wdata(a_wdata), .rdata(a_rdata), .irq(a_irq),
      .tx_push(a_push), .rx_pop(a_pop), .rx_data(ba_data),
      .rx_full(ba_full), .tx_full(ab_full),
      .req_out(a_req), .req_in(b_req), .flag_out(a_flag), .flag_in(b_flag));

   msgu_side #(.NCH(NCH), .NFLAG(NFLAG), .DW(DW), .AW(AW)) u_side_b (
      .clk(clk), .rst_n(rst_n), .wr(b_wr), .rd(b_rd), .addr(b_addr),
      .wdata(b_wdata), .rdata(b_rdata), .irq(b_irq),
      .tx_push(b_push), .rx_pop(b_pop), .rx_data(ab_data),
      .rx_full(ab_full), .tx_full(ba_full),
      .req_out(b_req), .req_in(a_req), .flag_out(b_flag), .flag_in(a_flag));

   AST_FLAG_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && a_addr == 6'h24) |=> (a_flag == $past(a_wdata[NFLAG-1:0]))); // R8
   AST_IRQ_RESET: assert property (@(posedge clk)
      !rst_n |=> (!a_irq && !b_irq));                                   // R1
endmodule

// File: tb/dual_msg_unit_tb_top.sv
module dual_msg_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
   logic [5:0]  a_addr = '0, b_addr = '0;
   logic [31:0] a_wdata = '0, b_wdata = '0;
   logic [31:0] a_rdata, b_rdata;
   logic        a_irq, b_irq;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   dual_msg_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_rdata(a_rdata), .a_irq(a_irq),
      .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
      .b_rdata(b_rdata), .b_irq(b_irq));

   typedef struct packed {
      logic        side;   // 0 = A, 1 = B
      logic        wr;
      logic [5:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 33;
   localparam vec_t VT [NV] = '{
      '{1'b0, 1'b0, 6'h20, 32'h0,        32'h00F00000, 4'd1},  // R1
      '{1'b1, 1'b0, 6'h20, 32'h0,        32'h00F00000, 4'd1},  // R1
      '{1'b0, 1'b0, 6'h24, 32'h0,        32'h00000000, 4'd1},  // R1
      '{1'b1, 1'b0, 6'h24, 32'h0,        32'h00000000, 4'd1},  // R1
      '{1'b0, 1'b1, 6'h04, 32'hDEADBEEF, 32'h0,        4'd2},  // R2
      '{1'b0, 1'b0, 6'h20, 32'h0,        32'h00B00000, 4'd2},  // R2
      '{1'b1, 1'b0, 6'h20, 32'h0,        32'h04F00000, 4'd2},  // R2
      '{1'b1, 1'b0, 6'h14, 32'h0,        32'hDEADBEEF, 4'd2},  // R2
      '{1'b1, 1'b0, 6'h20, 32'h0,        32'h00F00000, 4'd3},  // R3
      '{1'b0, 1'b0, 6'h20, 32'h0,        32'h00F00000, 4'd3},  // R3
      '{1'b1, 1'b1, 6'h0C, 32'h12345678, 32'h0,        4'd4},  // R4
      '{1'b0, 1'b0, 6'h20, 32'h0,        32'h01F00000, 4'd4},  // R4
      '{1'b1, 1'b0, 6'h20, 32'h0,        32'h00E00000, 4'd4},  // R4
      '{1'b0, 1'b1, 6'h1C, 32'hFFFFFFFF, 32'h0,        4'd10}, // R10
      '{1'b0, 1'b0, 6'h1C, 32'h0,        32'h12345678, 4'd10}, // R10
      '{1'b0, 1'b0, 6'h00, 32'h0,        32'h00000000, 4'd10}, // R10
      '{1'b0, 1'b0, 6'h28, 32'h0,        32'h00000000, 4'd10}, // R10
      '{1'b0, 1'b1, 6'h24, 32'h00000005, 32'h0,        4'd8},  // R8
      '{1'b1, 1'b0, 6'h20, 32'h0,        32'h00F00005, 4'd8},  // R8
      '{1'b0, 1'b0, 6'h24, 32'h0,        32'h00000005, 4'd5},  // R5
      '{1'b0, 1'b1, 6'h24, 32'h00020005, 32'h0,        4'd6},  // R6
      '{1'b0, 1'b0, 6'h24, 32'h0,        32'h00020005, 4'd6},  // R6
      '{1'b1, 1'b0, 6'h20, 32'h0,        32'h20F00005, 4'd6},  // R6
      '{1'b0, 1'b0, 6'h24, 32'h0,        32'h00000005, 4'd6},  // R6
      '{1'b1, 1'b1, 6'h20, 32'h00000000, 32'h0,        4'd7},  // R7
      '{1'b1, 1'b0, 6'h20, 32'h0,        32'h20F00005, 4'd7},  // R7
      '{1'b1, 1'b1, 6'h20, 32'h20000000, 32'h0,        4'd7},  // R7
      '{1'b1, 1'b0, 6'h20, 32'h0,        32'h00F00005, 4'd7},  // R7
      '{1'b1, 1'b1, 6'h20, 32'h00000200, 32'h0,        4'd10}, // R10
      '{1'b1, 1'b0, 6'h20, 32'h0,        32'h00F00005, 4'd10}, // R10
      '{1'b1, 1'b1, 6'h24, 32'hFFF00003, 32'h0,        4'd5},  // R5
      '{1'b1, 1'b0, 6'h24, 32'h0,        32'hFFF00003, 4'd5},  // R5
      '{1'b1, 1'b1, 6'h24, 32'h00000000, 32'h0,        4'd5}   // R5
   };

   task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   // one bus access on one side: driven at negedge, read data sampled before the edge
   task automatic op(input logic side, input logic wr, input logic [5:0] adr,
                     input logic [31:0] dat, input logic [31:0] exp, input int req);
      @(negedge clk);
      if (side) begin
         b_wr = wr; b_rd = !wr; b_addr = adr; b_wdata = dat;
      end else begin
         a_wr = wr; a_rd = !wr; a_addr = adr; a_wdata = dat;
      end
      #1;
      if (!wr) chk(req, side ? b_rdata : a_rdata, exp);
      @(posedge clk);
      #1;
      a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
   endtask

   task automatic chk_irq(input int req, input logic ea, input logic eb);
      @(negedge clk);
      chk(req, {31'd0, a_irq}, {31'd0, ea});
      chk(req, {31'd0, b_irq}, {31'd0, eb});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_irq(1, 1'b0, 1'b0);                          // R1 interrupts low

      for (int i = 0; i < NV; i++) begin
         op(VT[i].side, VT[i].wr, VT[i].addr, VT[i].data, VT[i].exp, int'(VT[i].req));
      end

      // R9: interrupt sources against enables
      chk_irq(9, 1'b0, 1'b0);
      op(0, 1, 6'h24, 32'h00800005, 0, 9);             // A tie0
      chk_irq(9, 1'b1, 1'b0);
      op(0, 1, 6'h00, 32'hCAFE0000, 0, 9);             // A fills slot 0
      chk_irq(9, 1'b0, 1'b0);
      op(1, 1, 6'h24, 32'h08000000, 0, 9);             // B rie0
      chk_irq(9, 1'b0, 1'b1);
      op(1, 0, 6'h10, 0, 32'hCAFE0000, 3);             // R3 read clears full
      chk_irq(9, 1'b1, 1'b0);

      // R6 doorbell into an enabled pending bit, R7 clear
      op(1, 1, 6'h24, 32'h40000000, 0, 6);             // B gie1
      op(0, 1, 6'h24, 32'h00040005, 0, 6);             // A request 1
      @(posedge clk);
      chk_irq(6, 1'b0, 1'b1);
      op(1, 1, 6'h20, 32'h40000000, 0, 7);
      chk_irq(7, 1'b0, 1'b0);

      // R11: write and read of the same slot in one cycle
      op(0, 1, 6'h08, 32'h00000111, 0, 11);
      @(negedge clk);
      a_wr = 1; a_addr = 6'h08; a_wdata = 32'h00000222;
      b_rd = 1; b_addr = 6'h18;
      #1;
      chk(11, b_rdata, 32'h00000111);
      @(posedge clk);
      #1;
      a_wr = 0; b_rd = 0;
      op(1, 0, 6'h20, 0, 32'h02F00005, 11);
      op(1, 0, 6'h18, 0, 32'h00000222, 11);

      // R1: reset again from a busy state
      op(0, 1, 6'h0C, 32'h55, 0, 1);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      op(0, 0, 6'h20, 0, 32'h00F00000, 1);
      op(1, 0, 6'h20, 0, 32'h00F00000, 1);
      op(0, 0, 6'h24, 0, 32'h00000000, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule